// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Start Gate

This block switches groups of output clocks on and off without ever emitting a truncated high pulse. Two groups are gated. The processor group is driven from `cpu_clk` and the bus group from `bus_clk`. Each group has its own active-low stop request. A third output carries the free-running bus-rate reference `ref_clk`. The stop requests never gate it. Only power-down and the settling interval after power-down silence it.

A stop or start request first passes through a two-flop synchroniser clocked by the reference. The gate then acts only on the next falling edge of the clock it controls. Because the enable changes only while the source clock is low, a stopped output sits low and every high phase it emits is a complete one.

Holding `pwrdn_n` low forces every output low at once and puts the power state in OFF. When `pwrdn_n` is released, a parameterised counter of reference cycles stands in for oscillator and PLL settling. Outputs stay low until that counter expires.

Top module: `clkstop_gate`

## Requirements
- R1: While a group is stopped, powered down or settling, its outputs are held at logic 0 during the high phase of the source clock as well as the low phase. While the group is enabled, each output equals its source clock.
- R2: `cpu_stop_n` = 0 requests a stop of the processor group and 1 requests it to run. A change is captured at the first `ref_clk` rising edge after the change. The outputs switch at the first `cpu_clk` falling edge after the second such `ref_clk` edge.
- R3: `bus_stop_n` controls the bus group with the same encoding and the same latency, with `bus_clk` as the gated clock.
- R4: Every high pulse on every output lasts exactly one full high phase of its source clock. This covers stop, start and the end of settling. The only exception is a pulse cut short by `pwrdn_n` falling.
- R5: `fr_gclk` is unaffected by either stop request. Outside power-down and settling it equals `ref_clk`.
- R6: When `pwrdn_n` goes low, all outputs go to 0 immediately and `pm_state` reads OFF, without waiting for a clock edge.
- R7: `pm_state` encoding is 2'b00 OFF, 2'b01 SETTLE, 2'b10 RUN. Count the `ref_clk` rising edges after `pwrdn_n` rises as 1, 2, and so on. `pm_state` is OFF after edges 1 and 2, SETTLE from edge 3, and RUN from edge SETTLE_CYC+3 onward. Once RUN, it stays RUN until `pwrdn_n` falls.
- R8: After power-down, a group that is not stopped starts at the first falling edge of its source clock following `ref_clk` edge SETTLE_CYC+4.
- R9: All copies within a group carry identical values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running bus-rate reference; clocks synchronisers and settle counter |
| cpu_clk | input | 1 | Source clock of the processor group |
| bus_clk | input | 1 | Source clock of the bus group |
| cpu_stop_n | input | 1 | Active-low stop request for the processor group |
| bus_stop_n | input | 1 | Active-low stop request for the bus group |
| pwrdn_n | input | 1 | Active-low power-down; also the block's asynchronous reset |
| cpu_gclk | output | N_CPU | Gated processor-group clocks |
| bus_gclk | output | N_BUS | Gated bus-group clocks |
| fr_gclk | output | 1 | Reference clock out, gated only by power state |
| pm_state | output | 2 | Power state: OFF, SETTLE or RUN |

## Verification
A request driven on a reference falling edge is captured at the next reference rising edge. It reaches a group at the first falling edge of that group's clock after one more reference rising edge. The earliest start after power-down falls on the first falling edge following reference edge SETTLE_CYC+4. The bench keeps its own counts of reference edges since each request change and since power-down release. At every falling edge of a source clock, it derives the expected enable from those counts. It then samples the gated outputs in the middle of the following high phase and the following low phase. `pm_state` is compared in the middle of each reference high phase against the edge count since release. The three source clocks are offset so that no falling edge of a gated clock coincides with a reference rising edge.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/100ps
package clkstop_pkg;

  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_SETTLE = 2'b01,
    PM_RUN    = 2'b10
  } pm_state_e;

  localparam int unsigned RST_STAGES = 2;

  // reference edge after release at which RUN becomes visible
  function automatic int unsigned run_edge(input int unsigned settle_cyc);
    return RST_STAGES + 1 + settle_cyc;
  endfunction

  // reference edge after which a group enable reaches its negedge flops
  function automatic int unsigned enable_edge(input int unsigned settle_cyc);
    return run_edge(settle_cyc) + 1;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/clkstop_rsync.sv
`timescale 1ns/100ps
module clkstop_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_settle.sv
`timescale 1ns/100ps
module clkstop_settle
  import clkstop_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 100000
) (
  input  logic      clk,
  input  logic      rst_n,
  output pm_state_e state,
  output logic      run
);
  localparam int unsigned CW = cnt_bits(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  pm_state_e     state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_OFF;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PM_OFF: begin
          state_q <= PM_SETTLE;
          cnt_q   <= '0;
        end
        PM_SETTLE: begin
          if (cnt_q == LAST) state_q <= PM_RUN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        PM_RUN:  state_q <= PM_RUN;
        default: state_q <= PM_OFF;
      endcase
    end
  end

  assign state = state_q;
  assign run   = (state_q == PM_RUN);

  // R7: once running, the state holds until reset
  p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN) |=> (state_q == PM_RUN));

  // R7: RUN is entered only from SETTLE with the count exhausted
  p_run_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(state_q == PM_SETTLE) && $past(cnt_q == LAST)));
endmodule

// File: rtl/clkstop_sync2.sv
`timescale 1ns/100ps
module clkstop_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic qual,
  output logic allow
);
  logic meta_q, allow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      meta_q  <= d;
      allow_q <= meta_q & qual;
    end
  end

  assign allow = allow_q;
endmodule

// File: rtl/clkstop_cell.sv
`timescale 1ns/100ps
module clkstop_cell #(
  parameter int unsigned COPIES = 1
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              allow,
  output logic [COPIES-1:0] gclk
);
  logic [COPIES-1:0] en_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    // enable moves only on the falling edge, so high phases stay whole
    always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b0;
      else        en_q[i] <= allow;
    end
    assign gclk[i] = clk_in & en_q[i];
  end
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/100ps
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned N_CPU      = 3,
  parameter int unsigned N_BUS      = 4,
  parameter int unsigned SETTLE_CYC = 100000
) (
  input  logic             ref_clk,
  input  logic             cpu_clk,
  input  logic             bus_clk,
  input  logic             cpu_stop_n,
  input  logic             bus_stop_n,
  input  logic             pwrdn_n,
  output logic [N_CPU-1:0] cpu_gclk,
  output logic [N_BUS-1:0] bus_gclk,
  output logic             fr_gclk,
  output logic [1:0]       pm_state
);
  logic      rst_ref_n;
  pm_state_e state;
  logic      run;
  logic      allow_cpu, allow_bus, allow_fr;
  logic [0:0] fr_vec;

  clkstop_rsync #(.STAGES(RST_STAGES)) u_rsync (
    .clk(ref_clk), .arst_n(pwrdn_n), .rst_sync_n(rst_ref_n));

  clkstop_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(ref_clk), .rst_n(rst_ref_n), .state(state), .run(run));

  clkstop_sync2 u_sync_cpu (
    .clk(ref_clk), .rst_n(rst_ref_n), .d(cpu_stop_n), .qual(run), .allow(allow_cpu));
  clkstop_sync2 u_sync_bus (
    .clk(ref_clk), .rst_n(rst_ref_n), .d(bus_stop_n), .qual(run), .allow(allow_bus));
  clkstop_sync2 u_sync_fr (
    .clk(ref_clk), .rst_n(rst_ref_n), .d(1'b1), .qual(run), .allow(allow_fr));

  clkstop_cell #(.COPIES(N_CPU)) u_cell_cpu (
    .clk_in(cpu_clk), .rst_n(pwrdn_n), .allow(allow_cpu), .gclk(cpu_gclk));
  clkstop_cell #(.COPIES(N_BUS)) u_cell_bus (
    .clk_in(bus_clk), .rst_n(pwrdn_n), .allow(allow_bus), .gclk(bus_gclk));
  clkstop_cell #(.COPIES(1)) u_cell_fr (
    .clk_in(ref_clk), .rst_n(pwrdn_n), .allow(allow_fr), .gclk(fr_vec));

  assign fr_gclk  = fr_vec[0];
  assign pm_state = state;

  // R8: no group is released while the power state is short of RUN
  p_gate_off_not_run_r8: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (state != PM_RUN) |=> !(allow_cpu || allow_bus || allow_fr));

  // R9: all copies of a group agree
  p_group_coherent_r9: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
    ((cpu_gclk == '0) || (cpu_gclk == '1)) && ((bus_gclk == '0) || (bus_gclk == '1)));
endmodule

// File: tb/clkstop_gate_tb.sv
`timescale 1ns/100ps
module clkstop_gate_tb_top;
  localparam int unsigned NC = 3;
  localparam int unsigned NB = 4;
  localparam int unsigned S  = 24;
  localparam int unsigned LIMIT_CYC = 150000;

  logic ref_clk = 1'b0, cpu_clk = 1'b0, bus_clk = 1'b0;
  logic cpu_stop_n = 1'b1, bus_stop_n = 1'b1, pwrdn_n = 1'b0;
  logic [NC-1:0] cpu_gclk;
  logic [NB-1:0] bus_gclk;
  logic fr_gclk;
  logic [1:0] pm_state;

  int checks = 0, failures = 0;
  bit finished = 0;

  clkstop_gate #(.N_CPU(NC), .N_BUS(NB), .SETTLE_CYC(S)) dut_i (
    .ref_clk(ref_clk), .cpu_clk(cpu_clk), .bus_clk(bus_clk),
    .cpu_stop_n(cpu_stop_n), .bus_stop_n(bus_stop_n), .pwrdn_n(pwrdn_n),
    .cpu_gclk(cpu_gclk), .bus_gclk(bus_gclk), .fr_gclk(fr_gclk), .pm_state(pm_state));

  always #10 ref_clk = ~ref_clk;
  initial begin #0.5; forever #3  cpu_clk = ~cpu_clk; end
  initial begin #5.5; forever #10 bus_clk = ~bus_clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // ---- reference model built from the requirements ----
  int unsigned e_pwr = 0;                 // ref edges since release (R7)
  int unsigned e_c = 9, e_b = 9;          // ref edges since request change
  bit cur_c = 1, prev_c = 1, cur_b = 1, prev_b = 1;
  bit exp_c = 0, exp_b = 0, exp_f = 0;
  realtime t_pd = -1.0;

  always @(posedge ref_clk) begin
    e_pwr <= !pwrdn_n ? 0 : (e_pwr < 1000000 ? e_pwr + 1 : e_pwr);
    if (cpu_stop_n != cur_c) begin prev_c <= cur_c; cur_c <= cpu_stop_n; e_c <= 1; end
    else if (e_c < 1000) e_c <= e_c + 1;
    if (bus_stop_n != cur_b) begin prev_b <= cur_b; cur_b <= bus_stop_n; e_b <= 1; end
    else if (e_b < 1000) e_b <= e_b + 1;
  end

  function automatic bit powered(input int unsigned edges);
    return edges >= S + 4;                // start edge of R8
  endfunction
  function automatic bit want(input bit cur, input bit prev, input int unsigned e);
    return (e >= 2) ? cur : prev;         // capture edge plus one (R2 R3)
  endfunction
  function automatic logic [1:0] exp_state(input int unsigned edges);
    if (edges < 3)     return 2'b00;
    if (edges < S + 3) return 2'b01;
    return 2'b10;
  endfunction

  always @(negedge cpu_clk or negedge pwrdn_n)
    if (!pwrdn_n) exp_c <= 1'b0; else exp_c <= powered(e_pwr) && want(cur_c, prev_c, e_c);
  always @(negedge bus_clk or negedge pwrdn_n)
    if (!pwrdn_n) exp_b <= 1'b0; else exp_b <= powered(e_pwr) && want(cur_b, prev_b, e_b);
  always @(negedge ref_clk or negedge pwrdn_n)
    if (!pwrdn_n) exp_f <= 1'b0; else exp_f <= powered(e_pwr);
  always @(negedge pwrdn_n) t_pd = $realtime;

  // ---- output checks in mid-phase ----
  always @(posedge cpu_clk) begin
    #1.5;
    chk(cpu_gclk == {NC{exp_c}}, "R2 R8 cpu high", int'(cpu_gclk), exp_c ? (1 << NC) - 1 : 0);
    chk(cpu_gclk == '0 || cpu_gclk == '1, "R9 cpu copies", int'(cpu_gclk), 0);
  end
  always @(negedge cpu_clk) begin
    #1.5;
    chk(cpu_gclk == '0, "R1 cpu low phase", int'(cpu_gclk), 0);
  end
  always @(posedge bus_clk) begin
    #5;
    chk(bus_gclk == {NB{exp_b}}, "R3 R8 bus high", int'(bus_gclk), exp_b ? (1 << NB) - 1 : 0);
    chk(bus_gclk == '0 || bus_gclk == '1, "R9 bus copies", int'(bus_gclk), 0);
  end
  always @(negedge bus_clk) begin
    #5;
    chk(bus_gclk == '0, "R1 bus low phase", int'(bus_gclk), 0);
  end
  always @(posedge ref_clk) begin
    #5;
    chk(fr_gclk == exp_f, "R5 free-running out", int'(fr_gclk), int'(exp_f));
    chk(pm_state == (pwrdn_n ? exp_state(e_pwr) : 2'b00), "R7 pm_state",
        int'(pm_state), int'(pwrdn_n ? exp_state(e_pwr) : 2'b00));
  end

  // ---- runt pulse monitors (R4) ----
  realtime rc = 0.0, rb = 0.0, rf = 0.0;
  always @(posedge cpu_gclk[0]) rc = $realtime;
  always @(negedge cpu_gclk[0])
    if (t_pd < rc) chk(($realtime - rc) > 2.95 && ($realtime - rc) < 3.05, "R4 cpu pulse",
                       int'(($realtime - rc) * 10), 30);
  always @(posedge bus_gclk[0]) rb = $realtime;
  always @(negedge bus_gclk[0])
    if (t_pd < rb) chk(($realtime - rb) > 9.95 && ($realtime - rb) < 10.05, "R4 bus pulse",
                       int'(($realtime - rb) * 10), 100);
  always @(posedge fr_gclk) rf = $realtime;
  always @(negedge fr_gclk)
    if (t_pd < rf) chk(($realtime - rf) > 9.95 && ($realtime - rf) < 10.05, "R4 ref pulse",
                       int'(($realtime - rf) * 10), 100);

  // ---- stimulus ----
  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_ref(4);
    // reset state (R6)
    chk(pm_state == 2'b00, "R6 reset pm_state", int'(pm_state), 0);
    chk(cpu_gclk == '0 && bus_gclk == '0 && fr_gclk == 1'b0, "R6 reset outputs",
        int'({fr_gclk, bus_gclk, cpu_gclk}), 0);
    pwrdn_n = 1'b1;
    wait_ref(2);
    chk(pm_state == 2'b00, "R7 off during sync", int'(pm_state), 0);
    wait_ref(2);
    chk(pm_state == 2'b01, "R7 settle", int'(pm_state), 1);
    wait_ref(S + 6);
    chk(pm_state == 2'b10, "R7 run", int'(pm_state), 2);
    // directed stops and starts
    cpu_stop_n = 1'b0; wait_ref(6);
    bus_stop_n = 1'b0; wait_ref(6);
    chk(fr_gclk == 1'b0 && cpu_gclk == '0, "R5 R1 stops applied", int'(cpu_gclk), 0);
    cpu_stop_n = 1'b1; wait_ref(3);
    bus_stop_n = 1'b1; wait_ref(6);
    // power-down while running (R6), checked right after the edge
    pwrdn_n = 1'b0; #1;
    chk(pm_state == 2'b00, "R6 immediate off", int'(pm_state), 0);
    chk(cpu_gclk == '0 && bus_gclk == '0 && fr_gclk == 1'b0, "R6 outputs low",
        int'({fr_gclk, bus_gclk, cpu_gclk}), 0);
    wait_ref(3);
    pwrdn_n = 1'b1; wait_ref(S + 8);
    // power-down while stopped, then release with the stop still set
    cpu_stop_n = 1'b0; wait_ref(4);
    pwrdn_n = 1'b0; wait_ref(2);
    pwrdn_n = 1'b1; wait_ref(S + 8);
    cpu_stop_n = 1'b1; wait_ref(5);
    // constrained random phase
    for (int it = 0; it < 300; it++) begin
      int unsigned pick = $urandom % 16;
      if (pick < 7)       cpu_stop_n = ~cpu_stop_n;
      else if (pick < 14) bus_stop_n = ~bus_stop_n;
      else begin
        pwrdn_n = 1'b0;
        wait_ref(2 + int'($urandom % 4));
        pwrdn_n = 1'b1;
      end
      wait_ref(3 + int'($urandom % 10));
    end
    wait_ref(S + 8);
    finish_run();
  end

  initial begin
    repeat (LIMIT_CYC) @(posedge ref_clk);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end
endmodule